// File: doc/BRIEF.md
# Auxiliary DAC Ramp Waveform Player

This block holds a small waveform table and plays it out, one word at a time, to the data input of an auxiliary DAC. A host loads the table through a single write port. It sets a load pointer, then streams data words that land at consecutive addresses. Once the table is loaded, the host issues a rising-ramp or falling-ramp command. The block then steps through the table, one word for each pulse from an external pacing divider. It shows the current word on its output and raises a busy flag for as long as the ramp runs.

A rising ramp plays addresses 1 through 63 and a falling ramp plays 62 down to 0. Each ramp is therefore exactly 63 paced reads. A falling ramp starts next to the top entry that a rising ramp ends on, and the reverse also holds. With the cyclic option set, the block plays rising and falling ramps back to back with no pause. One full output period then takes 126 step pulses. A write-protect input stops data writes while the DAC is switched to take its value from this block.

Top module: `auxramp_player`

## Requirements
- R1: After reset, `dac_word` is 0, `ramp_busy` is 0 and the load pointer is 0, so the first data write after reset lands at address 0.
- R2: A host write with `host_op` = 0 sets the load pointer to `host_wdata[5:0]`.
- R3: A host write with `host_op` = 1 stores `host_wdata` at the load pointer and then adds one to the pointer. The pointer wraps from 63 to 0, so writes on consecutive cycles fill the table in ascending order.
- R4: While `dac_sel` is 1, data writes (`host_op` = 1) change neither the table nor the load pointer.
- R5: A write with `host_op` = 2 while idle starts a rising ramp. Each following `step_tick` reads the next address from 1 to 63. The word read appears on `dac_word` on the cycle after the clock edge that sampled the tick.
- R6: A write with `host_op` = 3 while idle starts a falling ramp. Each following `step_tick` reads the next address from 62 down to 0.
- R7: `dac_word` holds its value on every cycle with no `step_tick`. A `step_tick` while idle changes neither `dac_word` nor `ramp_busy`.
- R8: `ramp_busy` goes high on the cycle after an accepted ramp command. It goes low on the cycle after the 63rd read of a ramp when `cyclic_en` is 0.
- R9: Ramp commands (`host_op` = 2 or 3) issued while `ramp_busy` is 1 are ignored. The running ramp continues in its own direction.
- R10: With `cyclic_en` at 1 at the end of a ramp, the opposite ramp starts at once and `ramp_busy` stays high. Clearing `cyclic_en` lets the current ramp finish and then stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe, one operation per cycle |
| host_op | input | 2 | 0 set pointer, 1 data write, 2 rising ramp, 3 falling ramp |
| host_wdata | input | 16 | Pointer value or data word |
| dac_sel | input | 1 | DAC driven by this block; blocks data writes |
| cyclic_en | input | 1 | Alternate rising and falling ramps without stopping |
| step_tick | input | 1 | Pacing pulse from the external divider |
| dac_word | output | 16 | Word presented to the DAC |
| ramp_busy | output | 1 | A ramp is in progress |

## Verification
The bench goes after the ramp end points and checks that each ramp makes exactly 63 reads. A design that is off by one would replay address 0 or 63, or leave busy set one step too long. It writes at pointer 63 and then once more. A pointer that does not wrap would lose the second word, and the falling ramp's final read of address 0 would show this. It makes a data write under `dac_sel` and then an unprotected write. A design that moves the pointer on the blocked write would put the second word one address too high. It also issues commands in mid-ramp and runs a cyclic ramp through both turnarounds. A design that restarts on a command, or pauses at a turnaround, would put words out of order.

// File: rtl/auxramp_pkg.sv
package auxramp_pkg;
   typedef enum logic [1:0] {
      OP_SETPTR = 2'd0,
      OP_WRITE  = 2'd1,
      OP_RISE   = 2'd2,
      OP_FALL   = 2'd3
   } host_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RISE = 2'd1,
      ST_FALL = 2'd2
   } ramp_st_e;
endpackage

// File: rtl/auxramp_store.sv
module auxramp_store #(
   parameter int W     = 16,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/auxramp_loader.sv
module auxramp_loader
   import auxramp_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    op,
   input  logic [W-1:0]  wdata,
   input  logic          protect,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [W-1:0]  mem_wdata
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [AW-1:0] ptr_q;
   logic [AW-1:0] ptr_inc;
   logic [AW-1:0] ptr_load;
   logic          take_ptr;
   logic          take_data;

   assign take_ptr  = wr_en && (op == OP_SETPTR);
   assign take_data = wr_en && (op == OP_WRITE) && !protect;

   generate
      if (POW2) begin : g_pow2
         assign ptr_inc  = ptr_q + 1'b1;
         assign ptr_load = wdata[AW-1:0];
      end else begin : g_mod
         assign ptr_inc  = (ptr_q == TOP) ? '0 : ptr_q + 1'b1;
         assign ptr_load = (wdata[AW-1:0] > TOP) ? '0 : wdata[AW-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (take_ptr) begin
         ptr_q <= ptr_load;
      end else if (take_data) begin
         ptr_q <= ptr_inc;
      end
   end

   assign mem_we    = take_data;
   assign mem_waddr = ptr_q;
   assign mem_wdata = wdata;

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_waddr == TOP) |=> (mem_waddr == '0)); // R3
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_waddr != TOP) |=> (mem_waddr == $past(mem_waddr) + 1'b1)); // R3
   AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_WRITE && protect) |=> $stable(mem_waddr)); // R4
   AST_PROTECT_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
      protect |-> !mem_we); // R4
endmodule

// File: rtl/auxramp_seq.sv
module auxramp_seq
   import auxramp_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_rise,
   input  logic          cmd_fall,
   input  logic          cyclic,
   input  logic          step,
   output logic [AW-1:0] rd_addr,
   input  logic [W-1:0]  rd_data,
   output logic [W-1:0]  dac_out,
   output logic          busy
);
   localparam logic [AW-1:0] TOP      = AW'(DEPTH - 1);
   localparam logic [AW-1:0] FALL_BEG = AW'(DEPTH - 2);
   localparam logic [AW-1:0] RISE_BEG = AW'(1);

   ramp_st_e      st_q;
   logic [AW-1:0] addr_q;
   logic [W-1:0]  out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         out_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_rise) begin
                  st_q   <= ST_RISE;
                  addr_q <= RISE_BEG;
               end else if (cmd_fall) begin
                  st_q   <= ST_FALL;
                  addr_q <= FALL_BEG;
               end
            end
            ST_RISE: begin
               if (step) begin
                  out_q <= rd_data;
                  if (addr_q == TOP) begin
                     if (cyclic) begin
                        st_q   <= ST_FALL;
                        addr_q <= FALL_BEG;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end else begin
                     addr_q <= addr_q + 1'b1;
                  end
               end
            end
            ST_FALL: begin
               if (step) begin
                  out_q <= rd_data;
                  if (addr_q == '0) begin
                     if (cyclic) begin
                        st_q   <= ST_RISE;
                        addr_q <= RISE_BEG;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end else begin
                     addr_q <= addr_q - 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_addr = addr_q;
   assign dac_out = out_q;
   assign busy    = (st_q != ST_IDLE);

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(dac_out)); // R7
   AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> ($stable(st_q) && $stable(rd_addr))); // R9
   AST_RISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RISE && step && rd_addr != TOP) |=> (rd_addr == $past(rd_addr) + 1'b1)); // R5
   AST_FALL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FALL && step && rd_addr != '0) |=> (rd_addr == $past(rd_addr) - 1'b1)); // R6
   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step && !cyclic && ((st_q == ST_RISE && rd_addr == TOP) ||
                                   (st_q == ST_FALL && rd_addr == '0))) |=> !busy); // R8
   AST_CYCLIC_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RISE && step && cyclic && rd_addr == TOP) |=> (busy && rd_addr == FALL_BEG)); // R10
endmodule

// File: rtl/auxramp_player.sv
module auxramp_player
   import auxramp_pkg::*;
#(
   parameter int W     = 16,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         host_wr_en,
   input  logic [1:0]   host_op,
   input  logic [W-1:0] host_wdata,
   input  logic         dac_sel,
   input  logic         cyclic_en,
   input  logic         step_tick,
   output logic [W-1:0] dac_word,
   output logic         ramp_busy
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 4 || DEPTH > 4096) begin : g_bad_depth
         $error("auxramp_player: DEPTH must be within 4..4096");
      end
      if (W < 1 || W < AW) begin : g_bad_width
         $error("auxramp_player: W must cover the pointer width");
      end
   endgenerate

   logic          mem_we;
   logic [AW-1:0] mem_waddr;
   logic [W-1:0]  mem_wdata;
   logic [AW-1:0] mem_raddr;
   logic [W-1:0]  mem_rdata;
   logic          cmd_rise;
   logic          cmd_fall;

   assign cmd_rise = host_wr_en && (host_op == OP_RISE);
   assign cmd_fall = host_wr_en && (host_op == OP_FALL);

   auxramp_loader #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (host_wr_en),
      .op        (host_op),
      .wdata     (host_wdata),
      .protect   (dac_sel),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata)
   );

   auxramp_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   auxramp_seq #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_rise (cmd_rise),
      .cmd_fall (cmd_fall),
      .cyclic   (cyclic_en),
      .step     (step_tick),
      .rd_addr  (mem_raddr),
      .rd_data  (mem_rdata),
      .dac_out  (dac_word),
      .busy     (ramp_busy)
   );

   AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ramp_busy && (cmd_rise || cmd_fall)) |=> ramp_busy); // R8
   AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!ramp_busy && step_tick && !cmd_rise && !cmd_fall) |=> (!ramp_busy && $stable(dac_word))); // R7
endmodule

// File: tb/auxramp_player_bench.sv
module auxramp_player_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [1:0]  host_op = 2'd0;
   logic [15:0] host_wdata = 16'h0;
   logic        dac_sel = 1'b0;
   logic        cyclic_en = 1'b0;
   logic        step_tick = 1'b0;
   logic        tick_chk = 1'b0;
   logic [15:0] dac_word;
   logic        ramp_busy;

   int total = 0;
   int bad = 0;
   logic [15:0] model_mem [64];
   int model_ptr = 0;
   logic [15:0] exp_q [$];
   string       tag_q [$];
   logic        fired = 1'b0;

   always #4 clk = ~clk;

   auxramp_player u_auxramp_player (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_op(host_op),
      .host_wdata(host_wdata), .dac_sel(dac_sel), .cyclic_en(cyclic_en),
      .step_tick(step_tick), .dac_word(dac_word), .ramp_busy(ramp_busy)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // monitor: scoreboard pops one expected word per checked step
   always @(posedge clk) fired <= step_tick && tick_chk;
   always @(negedge clk) begin
      if (fired) begin
         if (exp_q.size() == 0) check("SCOREBOARD", 16'hFFFF, 16'h0);
         else check(tag_q.pop_front(), dac_word, exp_q.pop_front());
      end
   end

   task automatic host(input logic [1:0] op, input logic [15:0] d);
      host_wr_en = 1'b1; host_op = op; host_wdata = d;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic put_word(input logic [15:0] d);
      if (!dac_sel) begin
         model_mem[model_ptr] = d;
         model_ptr = (model_ptr + 1) % 64;
      end
      host(2'd1, d);
   endtask

   task automatic step(input logic [15:0] exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      step_tick = 1'b1; tick_chk = 1'b1;
      @(negedge clk);
      step_tick = 1'b0; tick_chk = 1'b0;
   endtask

   task automatic play_rise(input string tag);
      for (int a = 1; a <= 63; a++) step(model_mem[a], tag);
   endtask

   task automatic play_fall(input string tag);
      for (int a = 62; a >= 0; a--) step(model_mem[a], tag);
   endtask

   initial begin
      #1_000_000;
      check("WATCHDOG", 16'd1, 16'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 dac_word", dac_word, 16'h0);
      check("R1 busy", {15'd0, ramp_busy}, 16'h0);

      // R1/R3: streamed load from reset pointer
      for (int i = 0; i < 64; i++) put_word(16'h0400 + 16'(i * 257));

      // R5 rising ramp, with R9 commands in mid-ramp
      host(2'd2, 16'h0);
      check("R8 busy up", {15'd0, ramp_busy}, 16'h1);
      for (int a = 1; a <= 63; a++) begin
         step(model_mem[a], "R5");
         if (a == 20) begin
            host(2'd3, 16'h0);
            host(2'd2, 16'h0);
            check("R9 busy kept", {15'd0, ramp_busy}, 16'h1);
         end
      end
      check("R8 busy end", {15'd0, ramp_busy}, 16'h0);

      // R6 falling ramp
      host(2'd3, 16'h0);
      play_fall("R6");
      check("R8 busy end down", {15'd0, ramp_busy}, 16'h0);

      // R7 hold and idle ticks
      repeat (5) @(negedge clk);
      check("R7 hold", dac_word, model_mem[0]);
      step_tick = 1'b1;
      @(negedge clk);
      step_tick = 1'b0;
      @(negedge clk);
      check("R7 idle tick out", dac_word, model_mem[0]);
      check("R7 idle tick busy", {15'd0, ramp_busy}, 16'h0);

      // R2 pointer load, R4 protect, R3 wrap
      host(2'd0, 16'd5); model_ptr = 5;
      dac_sel = 1'b1;
      put_word(16'hDEAD);
      dac_sel = 1'b0;
      put_word(16'hBEEF);
      host(2'd0, 16'd63); model_ptr = 63;
      put_word(16'h7777);
      put_word(16'h1111);
      host(2'd2, 16'h0);
      play_rise("R2 R3 R4");
      host(2'd3, 16'h0);
      play_fall("R3 wrap");

      // R10 cyclic
      cyclic_en = 1'b1;
      host(2'd2, 16'h0);
      play_rise("R10 up");
      check("R10 busy turn", {15'd0, ramp_busy}, 16'h1);
      play_fall("R10 down");
      check("R10 busy turn2", {15'd0, ramp_busy}, 16'h1);
      for (int a = 1; a <= 10; a++) step(model_mem[a], "R10 up2");
      cyclic_en = 1'b0;
      for (int a = 11; a <= 63; a++) step(model_mem[a], "R10 up2");
      check("R10 stop", {15'd0, ramp_busy}, 16'h0);

      repeat (2) @(negedge clk);
      check("SCOREBOARD empty", 16'(exp_q.size()), 16'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule